// File: doc/BRIEF.md
# Receive-Completion Interrupt Coalescer

This block sits beside a DMA engine and turns its per-descriptor completion pulses into a receive-done status bit and one level interrupt. A register port lets software pick between two modes. In direct mode each completion sets the status bit. In delayed mode completions are gathered, and the status bit is set only when one of two limits is reached: enough completions have piled up, or enough ticks have passed since the first pending completion. Whichever limit is reached first wins.

Software reads the status register, writes the value back to acknowledge it (write-one-to-clear), and may mask the line through the enable register while it services the ring. Completions that arrive while the status bit is already set are not lost. They count toward the next event.

Internally a two-state machine tracks gathering. `ST_IDLE` means nothing is pending. `ST_GATHER` means at least one completion is pending and the timer is running. The transitions are:
- `start`: `ST_IDLE` to `ST_GATHER`, on a completion that does not fire at once.
- `fire`: from either state back to `ST_IDLE`, when a limit is reached or delay mode is off.
- `hold`: `ST_GATHER` to `ST_GATHER`, while no limit has been reached.

Top module: `irq_coalescer`

## Requirements
- R1: After reset, the delay register (offset 0x20C) reads 0x0000_9414, and the status register (0x220) and the enable register (0x228) read 0. Any other offset reads 0.
- R2: In the delay register, bit 15 is the delay enable, bits 14:8 are the count limit and bits 6:0 are the time limit. All three are writable. The unused bits read 0, so writing all ones reads back 0x0000_FF7F.
- R3: When bit 15 is clear, or both limits are zero, each completion pulse sets status bit 16 at the clock edge that samples the pulse.
- R4: In delayed mode with a nonzero count limit N, status bit 16 is set at the edge that samples the Nth pending completion, and not before.
- R5: In delayed mode with a nonzero time limit T, the timer counts tick cycles that fall after the first pending completion. Status bit 16 is set at the edge that samples the Tth such tick. Ticks while nothing is pending are ignored.
- R6: Whichever limit is reached first sets the status bit. A limit field of zero never fires.
- R7: An event clears both the pending count and the timer. Completions that arrive while status bit 16 is already set count toward the next event.
- R8: Writing 1 to status bit 16 clears it, and writing 0 leaves it set. An event in the same cycle as the clearing write leaves the bit set.
- R9: Enable bit 16 is readable and writable. The interrupt equals status bit 16 AND enable bit 16. Setting the enable while the status bit is pending raises the interrupt one cycle after the write.
- R10: If delayed mode is switched off while completions are pending, status bit 16 is set at the next edge and the pending state is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpl_pulse | input | 1 | One-cycle completion pulse from the DMA engine |
| tick | input | 1 | Time base for the delay timer |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| irq | output | 1 | Level interrupt |

## Verification
A pending count or timer that is wrong shows up at the ports as a status bit that rises one edge early or late relative to the Nth completion or the Tth tick. The bench therefore samples status in the exact cycle of each expected edge and in the cycle before it. A lost accumulation shows only at the next event, so completions are fed while the status bit is still set and the next event is checked against that count. A wrong enable or clear path shows on `irq` within one cycle of the register write.

// File: rtl/coal_pkg.sv
package coal_pkg;
    localparam int THR_W     = 7;
    localparam int RXDONE_B  = 16;
    localparam int DLY_EN_B  = 15;
    localparam int CNT_LSB   = 8;
    localparam int TIME_LSB  = 0;

    localparam logic [11:0] OFF_DLY = 12'h20C;
    localparam logic [11:0] OFF_STS = 12'h220;
    localparam logic [11:0] OFF_IEN = 12'h228;

    localparam logic             RST_DLY_EN = 1'b1;
    localparam logic [THR_W-1:0] RST_CNT    = THR_W'(20);
    localparam logic [THR_W-1:0] RST_TIME   = THR_W'(20);

    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_GATHER = 1'b1
    } coal_state_e;
endpackage

// File: rtl/coal_regs.sv
module coal_regs
    import coal_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    input  logic              fire,
    output logic              dly_en,
    output logic [THR_W-1:0]  cnt_thr,
    output logic [THR_W-1:0]  time_thr,
    output logic              sts_q,
    output logic              ien_q
);
    localparam logic [ADDR_W-1:0] A_DLY = ADDR_W'(OFF_DLY);
    localparam logic [ADDR_W-1:0] A_STS = ADDR_W'(OFF_STS);
    localparam logic [ADDR_W-1:0] A_IEN = ADDR_W'(OFF_IEN);

    logic sel_dly, sel_sts, sel_ien;
    assign sel_dly = we && (addr == A_DLY);
    assign sel_sts = we && (addr == A_STS);
    assign sel_ien = we && (addr == A_IEN);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dly_en   <= RST_DLY_EN;
            cnt_thr  <= RST_CNT;
            time_thr <= RST_TIME;
            ien_q    <= 1'b0;
        end else begin
            if (sel_dly) begin
                dly_en   <= wdata[DLY_EN_B];
                cnt_thr  <= wdata[CNT_LSB +: THR_W];
                time_thr <= wdata[TIME_LSB +: THR_W];
            end
            if (sel_ien) ien_q <= wdata[RXDONE_B];
        end
    end

    // A completion event takes priority over a clearing write in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)                            sts_q <= 1'b0;
        else if (fire)                         sts_q <= 1'b1;
        else if (sel_sts && wdata[RXDONE_B])   sts_q <= 1'b0;
    end

    always_comb begin
        rdata = '0;
        unique case (addr)
            A_DLY: begin
                rdata[DLY_EN_B]             = dly_en;
                rdata[CNT_LSB +: THR_W]     = cnt_thr;
                rdata[TIME_LSB +: THR_W]    = time_thr;
            end
            A_STS:   rdata[RXDONE_B] = sts_q;
            A_IEN:   rdata[RXDONE_B] = ien_q;
            default: rdata = '0;
        endcase
    end

    logic unused_wbits;
    assign unused_wbits = ^{wdata[31:17], wdata[7]};
endmodule

// File: rtl/coal_fsm.sv
module coal_fsm
    import coal_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             delay_on,
    input  logic [THR_W-1:0] cnt_thr,
    input  logic [THR_W-1:0] time_thr,
    input  logic             done,
    input  logic             tick,
    output logic             fire,
    output coal_state_e      state_q,
    output logic [THR_W-1:0] cnt_q,
    output logic [THR_W-1:0] tmr_q
);
    coal_state_e      state_d;
    logic [THR_W-1:0] cnt_d, tmr_d;
    logic [THR_W:0]   cnt_sum, tmr_sum;
    logic             active, hit_cnt, hit_time;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            tmr_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            tmr_q   <= tmr_d;
        end
    end

    // Next state and outputs
    always_comb begin
        cnt_sum  = {1'b0, cnt_q} + (THR_W+1)'(done);
        tmr_sum  = {1'b0, tmr_q} + (THR_W+1)'(tick && (state_q == ST_GATHER));
        hit_cnt  = (cnt_thr  != '0) && (cnt_sum >= {1'b0, cnt_thr});
        hit_time = (time_thr != '0) && (tmr_sum >= {1'b0, time_thr});
        active   = 1'b0;
        unique case (state_q)
            ST_IDLE:   active = done;
            ST_GATHER: active = 1'b1;
            default:   active = 1'b0;
        endcase
        fire = active && (!delay_on || hit_cnt || hit_time);
        if (fire) begin
            state_d = ST_IDLE;
            cnt_d   = '0;
            tmr_d   = '0;
        end else if (active) begin
            state_d = ST_GATHER;
            cnt_d   = cnt_sum[THR_W] ? '1 : cnt_sum[THR_W-1:0];
            tmr_d   = tmr_sum[THR_W] ? '1 : tmr_sum[THR_W-1:0];
        end else begin
            state_d = ST_IDLE;
            cnt_d   = '0;
            tmr_d   = '0;
        end
    end
endmodule

// File: rtl/irq_coalescer.sv
module irq_coalescer
    import coal_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpl_pulse,
    input  logic              tick,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              irq
);
    logic             dly_en, sts_q, ien_q, fire, delay_on;
    logic [THR_W-1:0] cnt_thr, time_thr, cnt_q, tmr_q;
    coal_state_e      state_q;

    coal_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (reg_we),
        .addr     (reg_addr),
        .wdata    (reg_wdata),
        .rdata    (reg_rdata),
        .fire     (fire),
        .dly_en   (dly_en),
        .cnt_thr  (cnt_thr),
        .time_thr (time_thr),
        .sts_q    (sts_q),
        .ien_q    (ien_q)
    );

    assign delay_on = dly_en && ((cnt_thr != '0) || (time_thr != '0));

    coal_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .delay_on (delay_on),
        .cnt_thr  (cnt_thr),
        .time_thr (time_thr),
        .done     (cpl_pulse),
        .tick     (tick),
        .fire     (fire),
        .state_q  (state_q),
        .cnt_q    (cnt_q),
        .tmr_q    (tmr_q)
    );

    assign irq = sts_q && ien_q;
endmodule

// File: rtl/coal_chk.sv
module coal_chk
    import coal_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              delay_on,
    input logic              done,
    input logic              sts_q,
    input logic              irq,
    input logic              we,
    input logic [ADDR_W-1:0] addr,
    input logic [31:0]       wdata,
    input coal_state_e       state_q,
    input logic [THR_W-1:0]  cnt_q,
    input logic [THR_W-1:0]  tmr_q,
    input logic [THR_W-1:0]  cnt_thr
);
    logic clr_wr, ien_set_wr;
    assign clr_wr     = we && (addr == ADDR_W'(OFF_STS)) && wdata[RXDONE_B];
    assign ien_set_wr = we && (addr == ADDR_W'(OFF_IEN)) && wdata[RXDONE_B];

    // R3
    direct_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!delay_on && done) |=> sts_q);

    // R8
    sts_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_q && !clr_wr) |=> sts_q);

    // R4
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_GATHER && cnt_thr != '0 && $stable(cnt_thr)) |-> (cnt_q < cnt_thr));

    // R7
    idle_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> (cnt_q == '0 && tmr_q == '0));

    // R9
    reenable_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ien_set_wr && sts_q) |=> irq);

    // R10
    leave_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_GATHER && !delay_on) |=> (sts_q && state_q == ST_IDLE));
endmodule

bind irq_coalescer coal_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .delay_on (delay_on),
    .done     (cpl_pulse),
    .sts_q    (sts_q),
    .irq      (irq),
    .we       (reg_we),
    .addr     (reg_addr),
    .wdata    (reg_wdata),
    .state_q  (state_q),
    .cnt_q    (cnt_q),
    .tmr_q    (tmr_q),
    .cnt_thr  (cnt_thr)
);

// File: tb/tb_irq_coalescer.sv
module tb_irq_coalescer;
    localparam int ADDR_W = 12;
    localparam logic [11:0] A_DLY = 12'h20C;
    localparam logic [11:0] A_STS = 12'h220;
    localparam logic [11:0] A_IEN = 12'h228;
    localparam logic [31:0] RXD   = 32'h0001_0000;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cpl_pulse = 1'b0;
    logic              tick = 1'b0;
    logic              reg_we = 1'b0;
    logic [ADDR_W-1:0] reg_addr = '0;
    logic [31:0]       reg_wdata = '0;
    logic [31:0]       reg_rdata;
    logic              irq;

    always #4 clk = ~clk;

    irq_coalescer #(.ADDR_W(ADDR_W)) dut (
        .clk(clk), .rst_n(rst_n), .cpl_pulse(cpl_pulse), .tick(tick),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq(irq)
    );

    typedef struct {
        bit          is_irq;
        logic [31:0] exp;
        string       tag;
    } exp_item_t;

    exp_item_t sb_q[$];
    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit finished = 0;

    // Monitor: compares one expected item per cycle, away from the clock edge.
    always @(negedge clk) begin
        if (sb_q.size() > 0) begin
            exp_item_t it;
            logic [31:0] act;
            it = sb_q.pop_front();
            act = it.is_irq ? {31'b0, irq} : reg_rdata;
            checks++;
            if (act !== it.exp) begin
                errors++;
                $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
            end
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0d expected<100000", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic cyc();
        @(posedge clk);
        #2;
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        cyc();
        reg_we = 1'b0; reg_wdata = '0;
    endtask

    task automatic chk_rd(input logic [11:0] a, input logic [31:0] e, input string tag);
        exp_item_t it;
        reg_addr = a;
        it.is_irq = 0; it.exp = e; it.tag = tag;
        sb_q.push_back(it);
        cyc();
    endtask

    task automatic chk_irq(input logic e, input string tag);
        exp_item_t it;
        it.is_irq = 1; it.exp = {31'b0, e}; it.tag = tag;
        sb_q.push_back(it);
        cyc();
    endtask

    task automatic pulses(input int n);
        for (int i = 0; i < n; i++) begin
            cpl_pulse = 1'b1;
            cyc();
        end
        cpl_pulse = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            tick = 1'b1;
            cyc();
        end
        tick = 1'b0;
    endtask

    initial begin
        cyc(); cyc();
        rst_n = 1'b1;
        cyc();
        // R1: reset values
        chk_rd(A_DLY, 32'h0000_9414, "R1 dly reset");
        chk_rd(A_STS, 32'h0, "R1 sts reset");
        chk_rd(A_IEN, 32'h0, "R1 ien reset");
        chk_rd(12'h000, 32'h0, "R1 unmapped");
        chk_irq(1'b0, "R1 irq reset");
        // R2: field layout
        wr(A_DLY, 32'hFFFF_FFFF);
        chk_rd(A_DLY, 32'h0000_FF7F, "R2 dly mask");
        // R3: direct mode, delay bit clear
        wr(A_DLY, 32'h0000_0305);
        pulses(1);
        chk_rd(A_STS, RXD, "R3 direct set");
        chk_irq(1'b0, "R9 masked");
        // R8: write-one-to-clear
        wr(A_STS, 32'h0);
        chk_rd(A_STS, RXD, "R8 zero keeps");
        wr(A_STS, RXD);
        chk_rd(A_STS, 32'h0, "R8 one clears");
        // R3: delay bit set with both limits zero
        wr(A_DLY, 32'h0000_8000);
        pulses(1);
        chk_rd(A_STS, RXD, "R3 zero limits direct");
        wr(A_STS, RXD);
        // R4 / R6: count limit 3, time limit 0
        wr(A_DLY, 32'h0000_8300);
        pulses(1);
        ticks(10);
        chk_rd(A_STS, 32'h0, "R6 zero time never fires");
        pulses(1);
        chk_rd(A_STS, 32'h0, "R4 before Nth");
        pulses(1);
        chk_rd(A_STS, RXD, "R4 at Nth");
        // R7: completions during set status accumulate
        pulses(2);
        wr(A_STS, RXD);
        chk_rd(A_STS, 32'h0, "R7 cleared");
        pulses(1);
        chk_rd(A_STS, RXD, "R7 accumulated");
        wr(A_STS, RXD);
        // R5: time limit 4
        wr(A_DLY, 32'h0000_8004);
        ticks(10);
        chk_rd(A_STS, 32'h0, "R5 idle ticks ignored");
        cpl_pulse = 1'b1; tick = 1'b1; cyc();
        cpl_pulse = 1'b0; tick = 1'b0;
        ticks(3);
        chk_rd(A_STS, 32'h0, "R5 before T");
        ticks(1);
        chk_rd(A_STS, RXD, "R5 at T");
        wr(A_STS, RXD);
        // R6: whichever first, count 2 time 5
        wr(A_DLY, 32'h0000_8205);
        pulses(1);
        ticks(1);
        pulses(1);
        chk_rd(A_STS, RXD, "R6 count first");
        wr(A_STS, RXD);
        pulses(1);
        ticks(4);
        chk_rd(A_STS, 32'h0, "R6 time not yet");
        ticks(1);
        chk_rd(A_STS, RXD, "R6 time first");
        // R8: event wins over clear in same cycle
        wr(A_DLY, 32'h0);
        reg_we = 1'b1; reg_addr = A_STS; reg_wdata = RXD; cpl_pulse = 1'b1;
        cyc();
        reg_we = 1'b0; reg_wdata = '0; cpl_pulse = 1'b0;
        chk_rd(A_STS, RXD, "R8 event beats clear");
        // R9: enable and irq
        wr(A_IEN, RXD);
        chk_irq(1'b1, "R9 enable pending");
        chk_rd(A_IEN, RXD, "R9 ien readback");
        wr(A_IEN, 32'h0);
        chk_irq(1'b0, "R9 masked again");
        wr(A_IEN, RXD);
        chk_irq(1'b1, "R9 re-enable");
        wr(A_STS, RXD);
        chk_irq(1'b0, "R9 cleared drops irq");
        // R10: leave delay mode with pending completions
        wr(A_DLY, 32'h0000_8300);
        pulses(1);
        wr(A_DLY, 32'h0000_0300);
        chk_rd(A_STS, 32'h0, "R10 not yet");
        chk_rd(A_STS, RXD, "R10 flushed");
        wr(A_STS, RXD);
        wr(A_DLY, 32'h0000_8300);
        pulses(2);
        chk_rd(A_STS, 32'h0, "R10 pending cleared");
        cyc(); cyc();
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule